// File: doc/BRIEF.md
# Two-Wire Page Programming Slave

This block is the slave end of a two-wire programming link for a byte-addressed configuration store. A fast system clock oversamples the clock and data lines, finds start and stop conditions, and steps a state machine through the device byte, a three-byte memory address, and then either a run of written data or a run of read bytes. Written bytes are packed four at a time into 32-bit words. Each completed word is handed out on a one-cycle strobe with its address. That strobe goes to the array writer, or to a separate special-function decoder when the address is not word aligned. Read bytes come from an external byte port addressed by the block's own address counter.

A stop that closes a frame which wrote at least one word starts a timed write cycle. During that cycle the block is deaf to the bus, so a master can find out whether the write has finished by sending the device byte until it is acknowledged. The address counter survives between frames. This gives current-address reads, and random reads made of an address-only write frame followed by a repeated start.

States: `ST_IDLE` (waiting for a start), `ST_DEV` (receiving the device byte), `ST_ADDR` (receiving address bytes), `ST_WDATA` (receiving data bytes) and `ST_RDATA` (sending data bytes). Transitions:
- start (not busy): any state goes to `ST_DEV`.
- stop: any state goes to `ST_IDLE`.
- end of the device byte: `ST_DEV` goes to `ST_ADDR` (acknowledged write), to `ST_RDATA` (acknowledged read) or to `ST_IDLE` (refused).
- end of the last address byte: `ST_ADDR` goes to `ST_WDATA`.
- refused read byte: `ST_RDATA` goes to `ST_IDLE`.
- serial-enable high: any state goes to `ST_IDLE`.

Top module: `twi_prog_slave`

## Requirements
- R1: The device byte is received MSB first and is acknowledged only if it reads 1,0,1,0,A,1,1,D from first to last bit. A must equal `sel_a2` and the block must not be busy. D=1 selects a read and D=0 selects a write. A refused byte returns the block to waiting for a start.
- R2: After a write device byte, three address bytes follow, most significant byte first and each MSB first. Each byte is acknowledged, and the low 19 bits of the 24 received bits become the address.
- R3: Data bytes arrive LSB first. Each group of four bytes forms a word whose first byte is the least significant one. On the fourth byte, `wr_strobe` pulses for one cycle with the word in `wr_data`, its address in `wr_addr`, and `wr_special` set when the address bits [1:0] are not both zero. Every data byte is acknowledged.
- R4: After each word the address advances by 4 in its low 9 bits only, so writes wrap to the start of the same 512-byte page.
- R5: A stop after a frame that produced at least one word raises `busy` for exactly WR_CYCLES cycles. While busy, starts are ignored, no byte is acknowledged and no word is strobed. A stop after an address-only frame leaves `busy` low.
- R6: After a read device byte, bytes from `rd_byte` at `rd_addr` are sent LSB first. The address increments by one per byte, and sending continues while the master acknowledges. A refusal ends the read with the data line released.
- R7: The address is kept between frames. A current-address read continues at the address following the last byte accessed, and a random read uses the address from the preceding address-only frame.
- R8: While `ser_en_n` is high the block never pulls the data line and acknowledges nothing, and the address counter is cleared to zero.
- R9: `sda_pull` changes only while the bus clock is low.
- R10: During reset `sda_pull`, `busy` and `wr_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_en_n | input | 1 | Programming mode enable, active low |
| sel_a2 | input | 1 | Select level the device byte must match |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| busy | output | 1 | Timed write cycle in progress |
| rd_addr | output | 19 | Byte address for readback |
| rd_byte | input | 8 | Byte stored at `rd_addr` |
| wr_strobe | output | 1 | One-cycle pulse per completed word |
| wr_addr | output | 19 | Address of the strobed word |
| wr_data | output | 32 | Strobed word, first received byte in bits [7:0] |
| wr_special | output | 1 | Strobed address is not word aligned |

## Verification
The assertions assume that the master keeps the bus clock low for several system clocks after each falling edge before it raises it again. That margin is what lets a change of `sda_pull` land inside the low phase. They also assume that `ser_en_n` moves only while no frame is in flight. The stimulus holds every bus phase for six system clocks and toggles serial-enable only between frames, after a stop. The bus is modelled as a wired line, so the block sees its own acknowledge and data bits the way a real slave would.

// File: rtl/twi_prog_pkg.sv
package twi_prog_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } twi_state_e;

    localparam logic [3:0] DEV_TAG  = 4'b1010;
    localparam logic [1:0] DEV_TAIL = 2'b11;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_p} <= {scl_in, scl_m, scl_s};
            {sda_m, sda_s, sda_p} <= {sda_in, sda_m, sda_s};
        end
    end

    assign sda_lvl  = sda_s;
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
    parameter int CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (go)       cnt <= CW'(CYCLES);
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/twi_prog_slave.sv
module twi_prog_slave
    import twi_prog_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int PAGE_W    = 9,
    parameter int WR_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_n,
    input  logic              sel_a2,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_byte,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              wr_special
);
    localparam int ABYTES = (ADDR_W + 7) / 8;
    localparam int ASH_W  = ABYTES * 8;
    localparam int ACNT_W = $clog2(ABYTES + 1);

    twi_state_e state, state_d;

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_lvl;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg, tx;
    logic [ASH_W-1:0]  addr_sh;
    logic [ACNT_W-1:0] acnt;
    logic [1:0]        bidx;
    logic [23:0]       word_lo;
    logic [ADDR_W-1:0] cur_addr;
    logic ack_q, rnw_q, m_ack, wrote, wc_go;
    logic byte_end, ack_end, dev_ok;

    twi_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    twi_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(wc_go), .busy(busy)
    );

    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign ack_end  = scl_fall && (bitcnt == 4'd9);
    assign dev_ok   = (shreg[7:4] == DEV_TAG) && (shreg[3] == sel_a2) &&
                      (shreg[2:1] == DEV_TAIL) && !busy;
    assign rd_addr  = cur_addr;

    // next-state logic
    always_comb begin
        state_d = state;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = busy ? state : ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:  state_d = ST_IDLE;
                ST_DEV:   if (ack_end) state_d = !ack_q ? ST_IDLE :
                                                 (rnw_q ? ST_RDATA : ST_ADDR);
                ST_ADDR:  if (ack_end && acnt == ACNT_W'(ABYTES - 1)) state_d = ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: if (ack_end && !m_ack) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || ser_en_n) state <= ST_IDLE;
        else                    state <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        wr_strobe <= 1'b0;
        wc_go     <= 1'b0;
        if (!rst_n || ser_en_n) begin
            sda_pull   <= 1'b0;
            bitcnt     <= '0;
            shreg      <= '0;
            tx         <= '0;
            addr_sh    <= '0;
            acnt       <= '0;
            bidx       <= '0;
            word_lo    <= '0;
            cur_addr   <= '0;
            ack_q      <= 1'b0;
            rnw_q      <= 1'b0;
            m_ack      <= 1'b0;
            wrote      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_special <= 1'b0;
        end else if (stop_ev || (start_ev && !busy)) begin
            if (stop_ev && state == ST_WDATA && wrote) wc_go <= 1'b1;
            sda_pull <= 1'b0;
            bitcnt   <= '0;
            acnt     <= '0;
            bidx     <= '0;
            wrote    <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
                if (bitcnt < 4'd8) begin
                    if (state == ST_WDATA)      shreg <= {sda_lvl, shreg[7:1]};
                    else if (state != ST_RDATA) shreg <= {shreg[6:0], sda_lvl};
                end
                if (state == ST_RDATA && bitcnt == 4'd8) m_ack <= ~sda_lvl;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEV: begin
                        if (byte_end) begin
                            ack_q    <= dev_ok;
                            rnw_q    <= shreg[0];
                            sda_pull <= dev_ok;
                        end
                        if (ack_end) begin
                            bitcnt   <= '0;
                            acnt     <= '0;
                            bidx     <= '0;
                            wrote    <= 1'b0;
                            sda_pull <= 1'b0;
                            if (ack_q && rnw_q) begin
                                tx       <= rd_byte;
                                sda_pull <= ~rd_byte[0];
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (byte_end) begin
                            sda_pull <= 1'b1;
                            addr_sh  <= {addr_sh[ASH_W-9:0], shreg};
                        end
                        if (ack_end) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            acnt     <= acnt + 1'b1;
                            if (acnt == ACNT_W'(ABYTES - 1)) cur_addr <= addr_sh[ADDR_W-1:0];
                        end
                    end
                    ST_WDATA: begin
                        if (byte_end) begin
                            sda_pull <= 1'b1;
                            bidx     <= bidx + 2'd1;
                            unique case (bidx)
                                2'd0: word_lo[7:0]   <= shreg;
                                2'd1: word_lo[15:8]  <= shreg;
                                2'd2: word_lo[23:16] <= shreg;
                                2'd3: begin
                                    wr_strobe  <= 1'b1;
                                    wr_data    <= {shreg, word_lo};
                                    wr_addr    <= cur_addr;
                                    wr_special <= |cur_addr[1:0];
                                    cur_addr[PAGE_W-1:0] <= cur_addr[PAGE_W-1:0] + PAGE_W'(4);
                                    wrote      <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                        if (ack_end) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) sda_pull <= ~tx[bitcnt[2:0]];
                        if (byte_end) begin
                            sda_pull <= 1'b0;
                            cur_addr <= cur_addr + 1'b1;
                        end
                        if (ack_end) begin
                            bitcnt   <= '0;
                            sda_pull <= 1'b0;
                            if (m_ack) begin
                                tx       <= rd_byte;
                                sda_pull <= ~rd_byte[0];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_prog_slave_chk.sv
module twi_prog_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_en_n,
    input logic scl_in,
    input logic sda_pull,
    input logic busy,
    input logic wr_strobe
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= rst_n;

    assert_pull_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!ser_en_n && !$past(ser_en_n) && sda_pull != $past(sda_pull)) |-> !scl_in);

    assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (ser_en_n && $past(ser_en_n)) |-> !sda_pull);

    assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);

    assert_no_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_strobe);
endmodule

bind twi_prog_slave twi_prog_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .scl_in(scl_in),
    .sda_pull(sda_pull), .busy(busy), .wr_strobe(wr_strobe)
);

// File: tb/twi_prog_slave_tb.sv
module twi_prog_slave_tb;
    localparam int H   = 6;
    localparam int WRC = 400;
    localparam logic [7:0] DEV_W = 8'hA6;
    localparam logic [7:0] DEV_R = 8'hA7;

    logic clk = 1'b0;
    logic rst_n = 1'b0, ser_en_n = 1'b0, sel_a2 = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull, busy, wr_strobe, wr_special;
    logic [18:0] rd_addr, wr_addr;
    logic [31:0] wr_data;
    logic [7:0]  rd_byte;
    logic        sda_bus;
    logic [7:0]  mem [0:1023];

    int errors = 0, checks = 0;
    int strobe_cnt = 0, busy_total = 0, r9_viol = 0;
    logic [18:0] log_addr [0:7];
    logic [31:0] log_data [0:7];
    logic        log_spec [0:7];

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;
    assign rd_byte = mem[rd_addr[9:0]];

    twi_prog_slave #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .sel_a2(sel_a2),
        .scl_in(m_scl), .sda_in(sda_bus), .sda_pull(sda_pull), .busy(busy),
        .rd_addr(rd_addr), .rd_byte(rd_byte), .wr_strobe(wr_strobe),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_special(wr_special)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    logic prev_pull = 1'b0;
    always @(posedge clk) begin
        if (busy) busy_total <= busy_total + 1;
        prev_pull <= sda_pull;
        if (rst_n && sda_pull != prev_pull && m_scl) r9_viol <= r9_viol + 1;
        if (wr_strobe) begin
            log_addr[strobe_cnt[2:0]] <= wr_addr;
            log_data[strobe_cnt[2:0]] <= wr_data;
            log_spec[strobe_cnt[2:0]] <= wr_special;
            strobe_cnt <= strobe_cnt + 1;
            if (!wr_special)
                for (int b = 0; b < 4; b++) mem[wr_addr[9:0] + 10'(b)] <= wr_data[b*8 +: 8];
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bit(logic b);
        m_sda = b;    tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic send_byte(logic [7:0] b, bit msb, output bit ack);
        for (int i = 0; i < 8; i++) send_bit(msb ? b[7-i] : b[i]);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        ack = ~sda_bus; tick(H - H/2);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic recv_byte(bit ack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tick(H);
            m_scl = 1'b1; tick(H/2);
            b[i] = sda_bus; tick(H - H/2);
            m_scl = 1'b0; tick(H);
        end
        send_bit(ack ? 1'b0 : 1'b1);
    endtask

    task automatic send_addr(logic [18:0] a, inout bit all);
        bit k;
        send_byte({5'b0, a[18:16]}, 1'b1, k); all &= k;
        send_byte(a[15:8], 1'b1, k);          all &= k;
        send_byte(a[7:0], 1'b1, k);           all &= k;
    endtask

    task automatic do_write(logic [18:0] a, logic [31:0] w0, logic [31:0] w1,
                            int nw, output bit all);
        bit k;
        all = 1'b1;
        bus_start();
        send_byte(DEV_W, 1'b1, k); all &= k;
        send_addr(a, all);
        for (int w = 0; w < nw; w++)
            for (int b = 0; b < 4; b++) begin
                send_byte(w == 0 ? w0[b*8 +: 8] : w1[b*8 +: 8], 1'b0, k);
                all &= k;
            end
        bus_stop();
    endtask

    task automatic read_bytes(int n, output logic [31:0] got);
        logic [7:0] b;
        got = '0;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            got[i*8 +: 8] = b;
        end
        check(sda_pull == 1'b0, "R6 line released after refusal", 32'(sda_pull), 32'h0);
        bus_stop();
    endtask

    task automatic rd_random(logic [18:0] a, int n, output logic [31:0] got, output bit all);
        bit k;
        all = 1'b1;
        bus_start();
        send_byte(DEV_W, 1'b1, k); all &= k;
        send_addr(a, all);
        bus_start();
        send_byte(DEV_R, 1'b1, k); all &= k;
        read_bytes(n, got);
    endtask

    task automatic rd_current(int n, output logic [31:0] got);
        bit k;
        bus_start();
        send_byte(DEV_R, 1'b1, k);
        check(k, "R7 current read device ack", 32'(k), 32'h1);
        read_bytes(n, got);
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
        tick(2);
    endtask

    localparam logic [50:0] VEC [4] = '{
        {19'h00040, 32'h8421_F00D},
        {19'h12380, 32'h0000_0001},
        {19'h7FE08, 32'hFFFF_0000},
        {19'h00104, 32'hC3A5_5A3C}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok, k;
        logic [31:0] got;
        int s0, b0;
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        tick(5);
        check(sda_pull == 1'b0, "R10 reset pull", 32'(sda_pull), 32'h0);
        check(busy == 1'b0, "R10 reset busy", 32'(busy), 32'h0);
        check(wr_strobe == 1'b0, "R10 reset strobe", 32'(wr_strobe), 32'h0);
        rst_n = 1'b1;
        tick(5);

        // table-driven write then random read back
        for (int v = 0; v < 4; v++) begin
            s0 = strobe_cnt;
            do_write(VEC[v][50:32], VEC[v][31:0], 32'h0, 1, ok);
            check(ok, "R1 R2 R3 write frame acks", 32'(ok), 32'h1);
            check(strobe_cnt == s0 + 1, "R3 one strobe per word", 32'(strobe_cnt - s0), 32'h1);
            check(log_addr[s0[2:0]] == VEC[v][50:32], "R2 strobe address",
                  32'(log_addr[s0[2:0]]), 32'(VEC[v][50:32]));
            check(log_data[s0[2:0]] == VEC[v][31:0] && !log_spec[s0[2:0]], "R3 strobe word",
                  log_data[s0[2:0]], VEC[v][31:0]);
            wait_idle();
            rd_random(VEC[v][50:32], 4, got, ok);
            check(ok, "R7 random read acks", 32'(ok), 32'h1);
            check(got == VEC[v][31:0], "R6 R7 readback", got, VEC[v][31:0]);
        end

        // R1: select bit mismatch, then match; R5: address-only frame sets no busy
        sel_a2 = 1'b1;
        bus_start();
        send_byte(DEV_W, 1'b1, k);
        check(!k, "R1 select mismatch refused", 32'(k), 32'h0);
        bus_stop();
        bus_start();
        send_byte(8'hAE, 1'b1, k);
        check(k, "R1 select match acknowledged", 32'(k), 32'h1);
        bus_stop();
        tick(20);
        check(!busy, "R5 no busy after address-only frame", 32'(busy), 32'h0);
        sel_a2 = 1'b0;

        // R4: two words from the last word of a page wrap to its start
        s0 = strobe_cnt;
        b0 = busy_total;
        do_write(19'h003FC, 32'h1111_2222, 32'h3333_4444, 2, ok);
        check(log_addr[s0[2:0]] == 19'h003FC, "R4 first word address",
              32'(log_addr[s0[2:0]]), 32'h3FC);
        check(log_addr[3'(s0 + 1)] == 19'h00200, "R4 wrapped word address",
              32'(log_addr[3'(s0 + 1)]), 32'h200);
        tick(4);
        check(busy, "R5 busy after write stop", 32'(busy), 32'h1);
        bus_start();
        send_byte(DEV_W, 1'b1, k);
        check(!k, "R5 device refused while busy", 32'(k), 32'h0);
        bus_stop();
        wait_idle();
        check(busy_total - b0 == WRC, "R5 busy length", 32'(busy_total - b0), 32'(WRC));
        bus_start();
        send_byte(DEV_W, 1'b1, k);
        check(k, "R5 poll acknowledged after cycle", 32'(k), 32'h1);
        bus_stop();

        // R7: current-address reads continue after the wrapped write
        rd_current(2, got);
        check(got[15:0] == {pat(16'h205), pat(16'h204)}, "R7 current read after write",
              got, {16'h0, pat(16'h205), pat(16'h204)});
        rd_current(1, got);
        check(got[7:0] == pat(16'h206), "R7 current read retained",
              got, {24'h0, pat(16'h206)});

        // R3: unaligned address is flagged for the special decoder
        s0 = strobe_cnt;
        do_write(19'h55555, 32'h0000_00A0, 32'h0, 1, ok);
        check(ok && log_spec[s0[2:0]] && log_addr[s0[2:0]] == 19'h55555,
              "R3 unaligned word flagged", 32'(log_addr[s0[2:0]]), 32'h55555);
        wait_idle();

        // R8: disabled block stays silent and clears its address
        ser_en_n = 1'b1;
        tick(4);
        bus_start();
        send_byte(DEV_W, 1'b1, k);
        check(!k, "R8 no ack while disabled", 32'(k), 32'h0);
        bus_stop();
        ser_en_n = 1'b0;
        tick(4);
        rd_current(1, got);
        check(got[7:0] == pat(0), "R8 address cleared", got, {24'h0, pat(0)});

        check(r9_viol == 0, "R9 pull changes with clock low", 32'(r9_viol), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule